// File: doc/BRIEF.md
# Strobed Byte-Wide I/O Port with Service Request

This block is a byte-wide port for a processor bus. It holds one word in a data store that is transparent while its gate is high. A two-line chip-select decoder chooses when the port is addressed. A mode input decides two things: whether the gate comes from the chip select or from a strobe line, and whether the output drivers are always on or follow the chip select. A small state machine records a service request on each falling strobe edge and reports it on an active-low interrupt line. Addressing the port withdraws the request.

This version runs in a single clock domain. Every control input is sampled on `clk`. The store is a register whose value is bypassed while the gate is high, so the output follows the input in that same cycle. The strobe falling edge is found by comparing the strobe with its value one clock earlier. The output drivers are shown as a data bus plus an enable bit, where enable low means high impedance, and the data bus reads zero while the enable is low.

The request state machine has two states. **SRQ_IDLE** means no request is waiting. **SRQ_PEND** means a request is waiting. There are four transitions:
- *arm*: SRQ_IDLE to SRQ_PEND on a strobe fall, when the port is not addressed and the clear is high.
- *ack*: SRQ_PEND to SRQ_IDLE while the port is addressed.
- *flush*: SRQ_PEND to SRQ_IDLE while the clear is low.
- *hold*: the state stays as it is in every other case.

Top module: `strobed_io_port`

## Requirements
- R1: The port is addressed only when `sel_lo_n` is 0 and `sel_hi` is 1 in the same cycle.
- R2: With `mode`=1, `dout_en` is always 1 and the store gate is the addressed condition.
- R3: With `mode`=0, `dout_en` equals the addressed condition and the store gate is `strobe`.
- R4: While the gate is high, `dout` equals `din` in that same cycle, if `dout_en` is 1.
- R5: When the gate is low and `clear_n` is 1, the store keeps the `din` value sampled at the last clock edge at which the gate was high.
- R6: When `clear_n` is 0 and the gate is low, the store becomes 0 from the next edge. When `clear_n` is 0 and the gate is high, the clear has no effect and the store loads `din`.
- R7: While `dout_en` is 0, `dout` is all zeros.
- R8: A strobe fall is 1 sampled at one edge and 0 at the next. A strobe fall while the port is not addressed and `clear_n` is 1 moves the state machine from SRQ_IDLE to SRQ_PEND at that edge.
- R9: While the port is addressed, the state machine goes to SRQ_IDLE at the next edge. An address during a strobe fall wins over the fall.
- R10: `clear_n`=0 sends the state machine to SRQ_IDLE at the next edge and blocks a strobe fall in that cycle.
- R11: `irq_n` is 0 when the state machine is in SRQ_PEND or the port is addressed, and 1 otherwise.
- R12: With `rst_n` low, the store is 0, the state machine is in SRQ_IDLE, and the strobe history is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Data input word |
| sel_lo_n | input | 1 | Chip-select term, active low |
| sel_hi | input | 1 | Chip-select term, active high |
| mode | input | 1 | 1: drivers always on, gate from select; 0: drivers from select, gate from strobe |
| strobe | input | 1 | Strobe; gate in mode 0, falling edge raises a request |
| clear_n | input | 1 | Clear for store and request, active low |
| dout | output | 8 | Output word (zero while disabled) |
| dout_en | output | 1 | Driver enable; 0 means high impedance |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench walks through every combination of mode, strobe and select from the data-out table, using a new input word on each row. A design with the mode multiplexer swapped, or with a decoder that accepts the wrong polarity on one select term, then shows a stale or floating word. A clear applied while the store is transparent must leave the output tracking `din`; a design that lets the clear win shows zeros. The request sequence (strobe fall, interrupt low, address, request gone after deselect) catches a machine that never arms, never acknowledges, or reacts to the rising edge. A fall while the clear is low or while the port is addressed must not leave a request behind.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic {
        SRQ_IDLE = 1'b0,
        SRQ_PEND = 1'b1
    } srq_state_e;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic sel_lo_n,
    input  logic sel_hi,
    input  logic strobe,
    output logic addressed,
    output logic gate,
    output logic drv_en
);
    always_comb begin
        addressed = !sel_lo_n && sel_hi;
        gate      = mode ? addressed : strobe;
        drv_en    = mode ? 1'b1 : addressed;
    end

    AST_MODE1_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> drv_en);                                   // R2
    AST_MODE0_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (drv_en == (!sel_lo_n && sel_hi)));       // R3
endmodule

// File: rtl/sio_store.sv
module sio_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] view
);
    logic [WIDTH-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else if (gate)
            held <= din;
        else if (!clear_n)
            held <= '0;
    end

    assign view = gate ? din : held;

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && clear_n) |=> (held == $past(held)));      // R5
    AST_STORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !clear_n) |=> (held == '0));              // R6
    AST_GATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> (held == $past(din)));                     // R6
endmodule

// File: rtl/sio_srq.sv
module sio_srq
    import sio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic addressed,
    input  logic clear_n,
    output logic pending
);
    srq_state_e state, state_nx;
    logic       strobe_q;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= strobe;
    end

    assign fall = strobe_q && !strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SRQ_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRQ_IDLE: if (fall && !addressed && clear_n) state_nx = SRQ_PEND;
            SRQ_PEND: if (addressed || !clear_n)         state_nx = SRQ_IDLE;
            default:                                     state_nx = SRQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == SRQ_PEND);
    end

    AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !addressed && clear_n) |=> pending);       // R8
    AST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        addressed |=> !pending);                            // R9
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> !pending);                             // R10
endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             sel_lo_n,
    input  logic             sel_hi,
    input  logic             mode,
    input  logic             strobe,
    input  logic             clear_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             irq_n
);
    logic             addressed;
    logic             gate;
    logic             drv_en;
    logic             pending;
    logic [WIDTH-1:0] view;

    sio_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .sel_lo_n  (sel_lo_n),
        .sel_hi    (sel_hi),
        .strobe    (strobe),
        .addressed (addressed),
        .gate      (gate),
        .drv_en    (drv_en)
    );

    sio_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate),
        .clear_n (clear_n),
        .din     (din),
        .view    (view)
    );

    sio_srq u_srq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .addressed (addressed),
        .clear_n   (clear_n),
        .pending   (pending)
    );

    always_comb begin
        dout_en = drv_en;
        dout    = drv_en ? view : '0;
        irq_n   = !(pending || addressed);
    end

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));                          // R7
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && dout_en) |-> (dout == din));                // R4
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi) |-> !irq_n);                   // R11
endmodule

// File: tb/test_strobed_io_port.sv
module test_strobed_io_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       sel_lo_n = 1'b1;
    logic       sel_hi = 1'b0;
    logic       mode = 1'b1;
    logic       strobe = 1'b0;
    logic       clear_n = 1'b1;
    logic [7:0] dout;
    logic       dout_en;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strobed_io_port i_strobed_io_port (
        .clk(clk), .rst_n(rst_n), .din(din), .sel_lo_n(sel_lo_n),
        .sel_hi(sel_hi), .mode(mode), .strobe(strobe), .clear_n(clear_n),
        .dout(dout), .dout_en(dout_en), .irq_n(irq_n)
    );

    // row: din[20:13] mode[12] strobe[11] sel_lo_n[10] sel_hi[9] en[8] dout[7:0]
    localparam logic [20:0] VEC [10] = '{
        {8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5},
        {8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
        {8'h44, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5},
        {8'h55, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h66, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55},
        {8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h77},
        {8'h88, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h88},
        {8'h99, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88},
        {8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] d, input logic m, input logic s,
                         input logic ln, input logic h, input logic c);
        din = d; mode = m; strobe = s; sel_lo_n = ln; sel_hi = h; clear_n = c;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset state, mode 1, not addressed
        repeat (3) @(negedge clk);
        #2;
        check("R12 dout", {dout_en, dout}, {1'b1, 8'h00});
        check("R12 irq_n", {8'h00, irq_n}, 9'h001);
        @(negedge clk); rst_n = 1'b1;

        // preload store with A5 via mode 1 select
        drive(8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);

        // R1 R2 R3 R4 R5 R7: data-out combinations
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], 1'b1);
            #2;
            check($sformatf("R1/R2/R3/R4/R5/R7 row %0d", i),
                  {dout_en, dout}, VEC[i][8:0]);
            @(negedge clk);
        end

        // R1: one select term wrong each way, mode 0
        drive(8'h10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1); #2;
        check("R1 lo_n high", {8'h00, dout_en}, 9'h000);
        drive(8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #2;
        check("R1 hi low", {8'h00, dout_en}, 9'h000);
        @(negedge clk);

        // R6: clear with gate low
        drive(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); @(negedge clk);
        drive(8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); @(negedge clk); #2;
        check("R6 cleared", {dout_en, dout}, {1'b1, 8'h00});
        // R6: clear overridden while transparent
        drive(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); #2;
        check("R6 override", {dout_en, dout}, {1'b1, 8'h5A});
        @(negedge clk);
        drive(8'hF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); #2;
        check("R5 held after override", {dout_en, dout}, {1'b1, 8'h5A});
        @(negedge clk);

        // R8 R9 R11: strobe fall, interrupt, address, request gone
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); #2;
        check("R11 idle high", {8'h00, irq_n}, 9'h001);
        @(negedge clk);
        drive(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); @(negedge clk); #2;
        check("R8 armed", {8'h00, irq_n}, 9'h000);
        @(negedge clk); #2;
        check("R8 still pending", {8'h00, irq_n}, 9'h000);
        drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); #2;
        check("R11 low while addressed", {8'h00, irq_n}, 9'h000);
        @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); #2;
        check("R9 acknowledged", {8'h00, irq_n}, 9'h001);
        @(negedge clk);

        // R8: rising edge alone does not arm
        drive(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); @(negedge clk); #2;
        check("R8 rise ignored", {8'h00, irq_n}, 9'h001);

        // R9: fall while addressed is lost
        drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); #2;
        check("R9 fall while addressed", {8'h00, irq_n}, 9'h001);
        @(negedge clk);

        // R10: clear flushes a pending request
        drive(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); @(negedge clk); #2;
        check("R10 armed first", {8'h00, irq_n}, 9'h000);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); @(negedge clk); #2;
        check("R10 flushed", {8'h00, irq_n}, 9'h001);

        // R10: clear blocks a fall
        drive(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); #2;
        check("R10 fall blocked", {8'h00, irq_n}, 9'h001);
        @(negedge clk);

        // R12: reset mid-run drops a pending request
        drive(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); @(negedge clk);
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); @(negedge clk);
        rst_n = 1'b0; #2;
        check("R12 reset flush", {8'h00, irq_n}, 9'h001);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule